// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for every received frame, whether its 48-bit destination address should be kept. Three mechanisms are combined: a bank of exact-match address slots, a 64-bin multicast hash table indexed by byte parities of the address, and a promiscuous override that keeps everything. Configuration arrives through a simple write port (address, data, enable) that loads the slots, sets or clears one hash bin per write, and updates a control word.

Frame parsing logic presents each destination address on the lookup port with a valid strobe. One clock later the block returns a valid flag, an accept flag and a two-bit reason code that says which mechanism admitted the frame. Lookup addresses are 48-bit values with the first byte on the wire in bits 47:40, so the group (multicast) flag is bit 40.

Top module: `rx_addr_filter`

## Requirements
- R1: A synchronous active-high reset clears every slot, every hash bin and the promiscuous bit, and drives res_valid, res_accept and res_reason to 0.
- R2: A lookup presented with lk_valid at one rising edge produces res_valid=1 with its result after that edge; in any cycle without a lookup, res_valid, res_accept and res_reason are 0, and res_accept is 1 exactly when res_reason is nonzero.
- R3: Slot k (0..7) is written as a low word at register 16+2k and a high word at 17+2k; the low word holds address bytes 0..3 with byte 0 (first on the wire, lookup bits 47:40) in bits 7:0, and the high word holds bytes 4..5 with byte 4 in bits 7:0; bits 31:16 of the high word are ignored.
- R4: A slot whose stored address is zero never matches, including a lookup of the all-zero address.
- R5: A lookup equal to the address in any slot, first or last included, is accepted with reason code 2.
- R6: The hash index bit 5−i is the XOR of lookup bits 8i+7..8i for i=0..5 (the parity of one byte each).
- R7: A write to register 1 writes the value of data bit 8 into the hash bin selected by data bits 5:0; 1 sets the bin and 0 clears it, and other bins are unchanged.
- R8: Only a group address (lookup bit 40 set) can be accepted through the hash table; such a lookup whose bin is set, with no other match, is accepted with reason code 3, and a unicast lookup whose bin is set is rejected.
- R9: Register 0 bit 4 is the promiscuous enable; while it is set every lookup is accepted with reason code 1, taking priority over all other matches.
- R10: When both a slot and the hash table match, the reason code is 2.
- R11: The broadcast address (all ones) is never accepted through a slot, even one holding all ones; it is accepted only by promiscuous mode or by its hash bin (index 0).
- R12: A configuration write and a lookup in the same cycle: the lookup result reflects the configuration before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 5 | Configuration register index |
| wr_data | input | 32 | Configuration write data |
| lk_valid | input | 1 | Lookup strobe |
| lk_addr | input | 48 | Destination address to classify |
| res_valid | output | 1 | Result valid, one cycle after lk_valid |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 2 | 0 reject, 1 promiscuous, 2 exact slot, 3 hash |

## Verification
The bench builds the filter with its default parameters: eight slots at register base 16, so both the first and last slot, the 64-bin table and the full byte-parity index are all reachable from the port. Hash indices are predicted with hand-worked values (bins 37, 36 and 0) and then cross-checked with an independent model, which brings the unicast-versus-group split on one shared bin within reach. Priority between the three paths, the broadcast exclusion from slots and a write colliding with a lookup in the same cycle are each set up deliberately.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int unsigned MAC_W      = 48;
  localparam int unsigned MAC_BYTES  = MAC_W / 8;
  localparam int unsigned HASH_IDX_W = MAC_BYTES;
  localparam int unsigned HASH_BINS  = 1 << HASH_IDX_W;

  typedef enum logic [1:0] {
    RSN_REJECT  = 2'd0,
    RSN_PROMISC = 2'd1,
    RSN_EXACT   = 2'd2,
    RSN_HASH    = 2'd3
  } rxf_reason_e;

  // Index bit (top - i) is the parity of byte i counted from the LSB end.
  function automatic logic [HASH_IDX_W-1:0] parity_index(input logic [MAC_W-1:0] a);
    logic [HASH_IDX_W-1:0] h;
    for (int i = 0; i < int'(MAC_BYTES); i++) begin
      h[HASH_IDX_W-1-i] = ^a[8*i +: 8];
    end
    return h;
  endfunction

  // Wire byte 0 sits in lo[7:0] but in bits 47:40 of the lookup value.
  function automatic logic [MAC_W-1:0] slot_value(input logic [31:0] lo,
                                                  input logic [15:0] hi);
    return {lo[7:0], lo[15:8], lo[23:16], lo[31:24], hi[7:0], hi[15:8]};
  endfunction

endpackage

// File: rtl/rxf_slot_bank.sv
module rxf_slot_bank
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned AW        = 5,
  parameter int unsigned SLOT_BASE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [MAC_W-1:0] lk_addr,
  output logic             any_hit
);

  logic [NUM_SLOTS-1:0] hit;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam logic [AW-1:0] LO_IDX = AW'(SLOT_BASE + 2*k);
    localparam logic [AW-1:0] HI_IDX = AW'(SLOT_BASE + 2*k + 1);
    logic [31:0]      lo_q;
    logic [15:0]      hi_q;
    logic [MAC_W-1:0] val;

    always_ff @(posedge clk) begin
      if (rst) begin
        lo_q <= '0;
        hi_q <= '0;
      end else if (wr_en) begin
        if (wr_addr == LO_IDX) lo_q <= wr_data;
        if (wr_addr == HI_IDX) hi_q <= wr_data[15:0];
      end
    end

    assign val    = slot_value(lo_q, hi_q);
    assign hit[k] = (val != '0) && (val == lk_addr);
  end

  assign any_hit = |hit;

  // R4: an empty slot cannot produce a hit on the zero address
  a_r4_zero_never_hits: assert property (@(posedge clk) disable iff (rst)
    any_hit |-> (lk_addr != '0));

endmodule

// File: rtl/rxf_hash_bins.sv
module rxf_hash_bins
  import rxf_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_bin_en,
  input  logic [HASH_IDX_W-1:0] wr_bin_idx,
  input  logic                  wr_bin_val,
  input  logic [MAC_W-1:0]      lk_addr,
  output logic                  group_hit
);

  logic [HASH_BINS-1:0]  bins_q;
  logic [HASH_IDX_W-1:0] lk_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      bins_q <= '0;
    end else if (wr_bin_en) begin
      bins_q[wr_bin_idx] <= wr_bin_val;
    end
  end

  assign lk_idx    = parity_index(lk_addr);
  assign group_hit = lk_addr[40] && bins_q[lk_idx];

  // R7: the addressed bin takes the written value
  a_r7_bin_written: assert property (@(posedge clk) disable iff (rst)
    wr_bin_en |=> (bins_q[$past(wr_bin_idx)] == $past(wr_bin_val)));

  // R8: a unicast lookup never reports a hash hit
  a_r8_unicast_no_hash: assert property (@(posedge clk) disable iff (rst)
    !lk_addr[40] |-> !group_hit);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int unsigned NUM_SLOTS   = 8,
  parameter int unsigned SLOT_BASE   = 16,
  parameter int unsigned CTRL_IDX    = 0,
  parameter int unsigned HASH_IDX    = 1,
  parameter int unsigned PROMISC_BIT = 4,
  parameter int unsigned BINVAL_BIT  = 8,
  parameter int unsigned AW          = $clog2(SLOT_BASE + 2*NUM_SLOTS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [31:0]      wr_data,
  input  logic             lk_valid,
  input  logic [MAC_W-1:0] lk_addr,
  output logic             res_valid,
  output logic             res_accept,
  output logic [1:0]       res_reason
);

  localparam logic [AW-1:0] CTRL_A = AW'(CTRL_IDX);
  localparam logic [AW-1:0] HASH_A = AW'(HASH_IDX);

  logic        promisc_q;
  logic        exact_hit;
  logic        hash_hit;
  logic        is_bcast;
  rxf_reason_e reason_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      promisc_q <= 1'b0;
    end else if (wr_en && wr_addr == CTRL_A) begin
      promisc_q <= wr_data[PROMISC_BIT];
    end
  end

  rxf_slot_bank #(
    .NUM_SLOTS (NUM_SLOTS),
    .AW        (AW),
    .SLOT_BASE (SLOT_BASE)
  ) u_slots (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lk_addr (lk_addr),
    .any_hit (exact_hit)
  );

  rxf_hash_bins u_hash (
    .clk        (clk),
    .rst        (rst),
    .wr_bin_en  (wr_en && wr_addr == HASH_A),
    .wr_bin_idx (wr_data[HASH_IDX_W-1:0]),
    .wr_bin_val (wr_data[BINVAL_BIT]),
    .lk_addr    (lk_addr),
    .group_hit  (hash_hit)
  );

  assign is_bcast = &lk_addr;

  always_comb begin
    if (promisc_q)                  reason_d = RSN_PROMISC;
    else if (exact_hit && !is_bcast) reason_d = RSN_EXACT;
    else if (hash_hit)              reason_d = RSN_HASH;
    else                            reason_d = RSN_REJECT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_reason <= RSN_REJECT;
    end else begin
      res_valid  <= lk_valid;
      res_accept <= lk_valid && (reason_d != RSN_REJECT);
      res_reason <= lk_valid ? reason_d : RSN_REJECT;
    end
  end

  // R2: result strobe follows the lookup strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> res_valid);

  // R2: quiet outputs when no lookup was presented
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> (!res_valid && !res_accept && res_reason == 2'd0));

  // R2: accept agrees with the reason code
  a_r2_accept_matches_reason: assert property (@(posedge clk) disable iff (rst)
    res_accept == (res_reason != 2'd0));

  // R9: promiscuous mode wins
  a_r9_promisc_wins: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && promisc_q) |=> (res_reason == RSN_PROMISC));

  // R11: broadcast is never reported as an exact match
  a_r11_bcast_not_exact: assert property (@(posedge clk) disable iff (rst)
    (lk_valid && is_bcast) |=> (res_reason != RSN_EXACT));

endmodule

// File: tb/rx_addr_filter_bench.sv
`timescale 1ns/1ps
module rx_addr_filter_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;
  logic        lk_valid;
  logic [47:0] lk_addr;
  logic        res_valid;
  logic        res_accept;
  logic [1:0]  res_reason;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .res_valid(res_valid),
    .res_accept(res_accept), .res_reason(res_reason)
  );

  localparam logic [47:0] A1    = 48'h02_11_22_33_44_55;
  localparam logic [47:0] A2    = 48'h0A_BB_CC_DD_EE_01;
  localparam logic [47:0] M1    = 48'h01_00_5E_00_00_FB; // bin 37
  localparam logic [47:0] U36   = 48'h00_00_5E_00_00_FB; // bin 36, unicast
  localparam logic [47:0] G36   = 48'h03_00_5E_00_00_FB; // bin 36, group
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF; // bin 0

  function automatic logic [5:0] model_idx(input logic [47:0] a);
    logic [5:0] h;
    for (int i = 0; i < 6; i++) h[5-i] = ^a[8*i +: 8];
    return h;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; wr_en = 1'b0; lk_valid = 1'b0; wr_addr = '0; wr_data = '0; lk_addr = '0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_slot(input int k, input logic [47:0] a);
    wr(5'(16 + 2*k), {a[23:16], a[31:24], a[39:32], a[47:40]});
    wr(5'(17 + 2*k), {16'hDEAD, a[7:0], a[15:8]});
  endtask

  task automatic set_bin(input logic [5:0] idx, input bit v);
    wr(5'd1, {23'd0, v, 2'b00, idx});
  endtask

  task automatic look(input string req, input logic [47:0] a, input logic [1:0] exp_rsn);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a;
    @(negedge clk);
    lk_valid = 1'b0;
    chk({req, " valid"}, 32'(res_valid), 32'd1);
    chk({req, " accept"}, 32'(res_accept), 32'(exp_rsn != 2'd0));
    chk({req, " reason"}, 32'(res_reason), 32'(exp_rsn));
  endtask

  task automatic t_reset();
    do_reset();
    load_slot(0, A1); set_bin(6'd37, 1'b1); wr(5'd0, 32'h10);
    do_reset();
    @(negedge clk);
    chk("R1 res_valid", 32'(res_valid), 32'd0);
    chk("R1 res_reason", 32'(res_reason), 32'd0);
    look("R1 slot cleared", A1, 2'd0);
    look("R1 bin cleared", M1, 2'd0);
    @(negedge clk);
    chk("R2 idle valid", 32'(res_valid), 32'd0);
    chk("R2 idle accept", 32'(res_accept), 32'd0);
  endtask

  task automatic t_exact();
    do_reset();
    wr(5'd16, 32'h33_22_11_02); // R3 literal packing of A1
    wr(5'd17, 32'hFFFF_5544);
    load_slot(7, A2);
    look("R3 packed slot0", A1, 2'd2);
    look("R3 byte order reversed", 48'h55_44_33_22_11_02, 2'd0);
    look("R5 last slot", A2, 2'd2);
    look("R5 no match", A2 ^ 48'h1, 2'd0);
  endtask

  task automatic t_zero();
    do_reset();
    look("R4 zero addr after reset", 48'h0, 2'd0);
    load_slot(2, A1);
    look("R4 programmed", A1, 2'd2);
    load_slot(2, 48'h0);
    look("R4 cleared slot", A1, 2'd0);
    look("R4 zero addr", 48'h0, 2'd0);
  endtask

  task automatic t_hash();
    do_reset();
    chk("R6 model bin37", 32'(model_idx(M1)), 32'd37);
    chk("R6 model bin36", 32'(model_idx(G36)), 32'd36);
    set_bin(6'd37, 1'b1);
    look("R6 bin37 hit", M1, 2'd3);
    set_bin(6'd36, 1'b1);
    look("R8 unicast on set bin", U36, 2'd0);
    look("R8 group on set bin", G36, 2'd3);
    set_bin(6'd37, 1'b0);
    look("R7 cleared bin37", M1, 2'd0);
    look("R7 bin36 untouched", G36, 2'd3);
    set_bin(6'd63, 1'b1);
    for (int n = 0; n < 64; n++) begin
      logic [47:0] g = {8'h01, 8'(n), 8'h5A, 8'(n * 7), 8'h3C, 8'(n * 3)};
      logic [5:0] ix = model_idx(g);
      look("R6 sweep", g, (ix == 6'd36 || ix == 6'd63) ? 2'd3 : 2'd0);
    end
  endtask

  task automatic t_priority();
    do_reset();
    load_slot(4, M1);
    set_bin(6'd37, 1'b1);
    look("R10 exact over hash", M1, 2'd2);
    wr(5'd0, 32'h0000_0010);
    look("R9 promisc over exact", M1, 2'd1);
    look("R9 promisc unknown", 48'h42_00_00_00_00_07, 2'd1);
    wr(5'd0, 32'hFFFF_FFEF);
    look("R9 promisc off", 48'h42_00_00_00_00_07, 2'd0);
  endtask

  task automatic t_bcast();
    do_reset();
    load_slot(3, BCAST);
    look("R11 slot of ones", BCAST, 2'd0);
    set_bin(6'd0, 1'b1);
    look("R11 via hash bin0", BCAST, 2'd3);
  endtask

  task automatic t_same_cycle();
    do_reset();
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'd1; wr_data = 32'h0000_0125;
    lk_valid = 1'b1; lk_addr = M1;
    @(negedge clk);
    wr_en = 1'b0; lk_valid = 1'b0;
    chk("R12 old state valid", 32'(res_valid), 32'd1);
    chk("R12 old state reason", 32'(res_reason), 32'd0);
    look("R12 new state", M1, 2'd3);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; lk_valid = 1'b0; wr_addr = '0; wr_data = '0; lk_addr = '0;
    t_reset();
    t_exact();
    t_zero();
    t_hash();
    t_priority();
    t_bcast();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule